// File: doc/BRIEF.md
# Directional key sequence acceptor

This block watches four directional push buttons and recognises one fixed eight-step pattern: up, up, down, down, left, right, left, right. Each raw button line first passes through a debouncer. A level change counts only after it has held steady for a set number of cycles. A two-bit history register then turns each debounced release into one pulse that lasts a single cycle. Pressing a key does nothing. Progress moves on only when the key is let go.

A four-bit state register follows the attempt. Every intermediate step has its own deadline. If the expected release does not arrive within the deadline, the attempt is rejected. A release of the wrong key also rejects it. A completed pattern ends in a held accept state. Both accept and reject stay put until another key is released, and that release returns the block to its idle state. The block outputs the state code along with separate accept and reject flags. A display stage outside this block can decode them.

Top module: `keyseq_acceptor`

## Requirements
- R1: After a synchronous active-high reset, `stateCode` is 0 (idle) and both `accepted` and `rejected` are low.
- R2: The key inputs are active high, with bit 0 for up, bit 1 for down, bit 2 for left and bit 3 for right. Pressing or holding a key never changes the state. Only its release does.
- R3: A level change on a key input that lasts fewer than `DEBOUNCE_CYCLES` consecutive cycles is ignored. A bouncing press followed by a steady press counts as one key.
- R4: Releasing the keys in the order up, up, down, down, left, right, left, right, starting from idle, ends in code 9 with `accepted` high.
- R5: In any intermediate state (codes 1 to 7), the release of any key other than the expected one gives code 10 with `rejected` high. This includes a release together with the expected key.
- R6: In an intermediate state, once `TIMEOUT_CYCLES` cycles have passed since entering it without any release, the state becomes code 10.
- R7: In idle, a release of down, left or right leaves the state at 0.
- R8: From code 9 or code 10, a release of any key returns the state to 0. Without a release, the state holds.
- R9: The state code follows the progress as 0 idle, 1 and 2 after the ups, 3 and 4 after the downs, 5 left, 6 right, 7 left, 9 accept and 10 reject. The code 8 and any code above 10 never appear.
- R10: Each debounced release produces exactly one step, however long the key was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| keyRaw | input | 4 | Raw button levels: bit 0 up, 1 down, 2 left, 3 right |
| stateCode | output | 4 | Current progress code |
| accepted | output | 1 | High while in the accept state |
| rejected | output | 1 | High while in the reject state |

## Verification
The bench runs a full correct pattern and holds one of the keys for a long time. This separates release-driven stepping from press-driven stepping, and shows that a single release gives a single step. It also applies short glitches and a bouncing press. These show whether the debouncer filters noise or passes extra events. Wrong keys, a simultaneous pair of releases and an idle wait past the deadline exercise the three different ways into reject. Stray releases in idle, and releases in accept and reject, separate the hold behaviour from the return to idle.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;
  localparam int KEY_COUNT = 4;
  localparam int KEY_UP    = 0;
  localparam int KEY_DOWN  = 1;
  localparam int KEY_LEFT  = 2;
  localparam int KEY_RIGHT = 3;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_U1   = 4'd1,
    ST_U2   = 4'd2,
    ST_D1   = 4'd3,
    ST_D2   = 4'd4,
    ST_L1   = 4'd5,
    ST_R1   = 4'd6,
    ST_L2   = 4'd7,
    ST_PASS = 4'd9,
    ST_DENY = 4'd10
  } seqState_t;

  typedef struct packed {
    logic timerRun;
    logic timerClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/keyseq_datapath.sv
module keyseq_datapath
  import keyseq_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 32000,
  parameter int TIMEOUT_CYCLES  = 32000000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [KEY_COUNT-1:0] keyRaw,
  input  ctrlStrobe_t          ctrl,
  output logic [KEY_COUNT-1:0] keyRelease,
  output logic                 timeoutHit
);
  localparam int DB_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int TM_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [KEY_COUNT-1:0] keyStable;

  for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
    logic [DB_W-1:0] runCnt;
    logic [1:0]      history;

    always_ff @(posedge clk) begin
      if (rst) begin
        runCnt       <= '0;
        keyStable[k] <= 1'b0;
      end else if (keyRaw[k] == keyStable[k]) begin
        runCnt <= '0;
      end else if (runCnt == DB_W'(DEBOUNCE_CYCLES - 1)) begin
        runCnt       <= '0;
        keyStable[k] <= keyRaw[k];
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) history <= 2'b00;
      else     history <= {history[0], keyStable[k]};
    end

    assign keyRelease[k] = (history == 2'b10);

    // R10
    release_single_chk: assert property (@(posedge clk) disable iff (rst)
      keyRelease[k] |=> !keyRelease[k]);

    // R3
    debounce_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (keyStable[k] != $past(keyStable[k])) |-> ($past(keyRaw[k]) == keyStable[k]));
  end

  logic [TM_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst || ctrl.timerClr) timer <= '0;
    else if (ctrl.timerRun)   timer <= timer + 1'b1;
  end

  assign timeoutHit = ctrl.timerRun && (timer == TM_W'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/keyseq_control.sv
module keyseq_control
  import keyseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [KEY_COUNT-1:0] keyRelease,
  input  logic                 timeoutHit,
  output ctrlStrobe_t          ctrl,
  output seqState_t            state
);
  seqState_t stateQ, stateD;
  logic [KEY_COUNT-1:0] expectMask;
  logic midStep;

  always_comb begin
    expectMask = '0;
    unique case (stateQ)
      ST_IDLE, ST_U1:       expectMask[KEY_UP]    = 1'b1;
      ST_U2, ST_D1:         expectMask[KEY_DOWN]  = 1'b1;
      ST_D2, ST_R1:         expectMask[KEY_LEFT]  = 1'b1;
      ST_L1, ST_L2:         expectMask[KEY_RIGHT] = 1'b1;
      default:              expectMask = '0;
    endcase
  end

  assign midStep = (stateQ != ST_IDLE) && (stateQ != ST_PASS) && (stateQ != ST_DENY);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:          if (|(keyRelease & expectMask)) stateD = ST_U1;
      ST_PASS, ST_DENY: if (|keyRelease) stateD = ST_IDLE;
      default: begin
        if (|(keyRelease & ~expectMask))     stateD = ST_DENY;
        else if (|(keyRelease & expectMask)) stateD = (stateQ == ST_L2) ? ST_PASS
                                                      : seqState_t'(stateQ + 4'd1);
        else if (timeoutHit)                 stateD = ST_DENY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign ctrl.timerRun = midStep;
  assign ctrl.timerClr = !midStep || (stateD != stateQ);
  assign state = stateQ;

  // R9
  state_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ != 4'd8) && (stateQ <= 4'd10));

  // R8
  hold_release_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_PASS || stateQ == ST_DENY) && (|keyRelease)) |=> (stateQ == ST_IDLE));

  // R6
  deadline_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (midStep && timeoutHit && !(|keyRelease)) |=> (stateQ == ST_DENY));

  // R4
  final_step_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_L2 && keyRelease == 4'b1000) |=> (stateQ == ST_PASS));
endmodule

// File: rtl/keyseq_acceptor.sv
module keyseq_acceptor
  import keyseq_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 32000,
  parameter int TIMEOUT_CYCLES  = 32000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] keyRaw,
  output logic [3:0] stateCode,
  output logic       accepted,
  output logic       rejected
);
  ctrlStrobe_t          ctrl;
  logic [KEY_COUNT-1:0] keyRelease;
  logic                 timeoutHit;
  seqState_t            state;

  keyseq_datapath #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .keyRaw    (keyRaw),
    .ctrl      (ctrl),
    .keyRelease(keyRelease),
    .timeoutHit(timeoutHit)
  );

  keyseq_control u_ctl (
    .clk       (clk),
    .rst       (rst),
    .keyRelease(keyRelease),
    .timeoutHit(timeoutHit),
    .ctrl      (ctrl),
    .state     (state)
  );

  assign stateCode = state;
  assign accepted  = (state == ST_PASS);
  assign rejected  = (state == ST_DENY);
endmodule

// File: tb/keyseq_acceptor_tb.sv
module keyseq_acceptor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 4;
  localparam int TO = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] keys = 4'b0;
  logic [3:0] stateCode;
  logic accepted, rejected;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyseq_acceptor #(.DEBOUNCE_CYCLES(DB), .TIMEOUT_CYCLES(TO)) u_dut (
    .clk(clk), .rst(rst), .keyRaw(keys),
    .stateCode(stateCode), .accepted(accepted), .rejected(rejected)
  );

  // behavioural reference model
  int mState;
  int mLvl[4], mRun[4], mNow[4], mOld[4];
  int mDwell;
  int wantKey[8] = '{0, 0, 1, 1, 2, 3, 2, 3};

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; mDwell = 0;
      for (int k = 0; k < 4; k++) begin mLvl[k] = 0; mRun[k] = 0; mNow[k] = 0; mOld[k] = 0; end
    end else begin
      int nxt;
      bit anyRel, wantRel, otherRel;
      anyRel = 0; wantRel = 0; otherRel = 0;
      for (int k = 0; k < 4; k++) begin
        if (mOld[k] == 1 && mNow[k] == 0) begin
          anyRel = 1;
          if (mState < 8 && wantKey[mState] == k) wantRel = 1;
          else otherRel = 1;
        end
      end
      nxt = mState;
      if (mState == 0) begin
        if (wantRel) nxt = 1;
      end else if (mState == 9 || mState == 10) begin
        if (anyRel) nxt = 0;
      end else begin
        if (otherRel) nxt = 10;
        else if (wantRel) nxt = (mState == 7) ? 9 : mState + 1;
        else if (mDwell == TO - 1) nxt = 10;
      end
      if (nxt != mState) mDwell = 0; else mDwell = mDwell + 1;
      mState = nxt;
      for (int k = 0; k < 4; k++) begin
        mOld[k] = mNow[k];
        mNow[k] = mLvl[k];
        if (int'(keys[k]) != mLvl[k]) begin
          mRun[k] = mRun[k] + 1;
          if (mRun[k] == DB) begin mLvl[k] = int'(keys[k]); mRun[k] = 0; end
        end else mRun[k] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (int'(stateCode) != mState || accepted != (mState == 9) || rejected != (mState == 10)) begin
        bad++;
        $display("FAIL R9 model compare: code=%0d acc=%0b rej=%0b expected code=%0d",
                 stateCode, accepted, rejected, mState);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tap(int k, int hold = 8);
    keys[k] = 1'b1; idle(hold);
    keys[k] = 1'b0; idle(12);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1
    chk("R1 code", int'(stateCode), 0);
    chk("R1 accepted", int'(accepted), 0);
    chk("R1 rejected", int'(rejected), 0);

    // R7 stray releases in idle
    tap(1); tap(2); tap(3);
    chk("R7 idle holds", int'(stateCode), 0);

    // R2 press held without release
    keys[0] = 1'b1; idle(30);
    chk("R2 press no step", int'(stateCode), 0);
    keys[0] = 1'b0; idle(12);
    chk("R2 release steps", int'(stateCode), 1);
    tap(2); tap(0);
    chk("R8 reject then clear", int'(stateCode), 0);

    // R3 short glitch
    keys[0] = 1'b1; idle(2); keys[0] = 1'b0; idle(12);
    chk("R3 glitch ignored", int'(stateCode), 0);
    // R3 R10 bouncing press
    keys[0] = 1'b1; idle(1); keys[0] = 1'b0; idle(1);
    keys[0] = 1'b1; idle(2); keys[0] = 1'b0; idle(1);
    keys[0] = 1'b1; idle(10);
    keys[0] = 1'b0; idle(1); keys[0] = 1'b1; idle(1); keys[0] = 1'b0; idle(12);
    chk("R3 bounce one step", int'(stateCode), 1);
    // R10 long hold
    tap(0, 60);
    chk("R10 long hold one step", int'(stateCode), 2);
    tap(1); tap(1); tap(2); tap(3); tap(2);
    chk("R9 code at left 2", int'(stateCode), 7);
    tap(3);
    chk("R4 code", int'(stateCode), 9);
    chk("R4 accepted", int'(accepted), 1);
    idle(300);
    chk("R8 accept holds", int'(stateCode), 9);
    tap(2);
    chk("R8 accept clear", int'(stateCode), 0);

    // R5 wrong key at third step
    tap(0); tap(0); tap(2);
    chk("R5 code", int'(stateCode), 10);
    chk("R5 rejected", int'(rejected), 1);
    idle(300);
    chk("R8 reject holds", int'(stateCode), 10);
    tap(3);
    chk("R8 reject clear", int'(stateCode), 0);

    // R5 simultaneous up and down in UP_1
    tap(0);
    keys = 4'b0011; idle(8); keys = 4'b0000; idle(12);
    chk("R5 pair release", int'(stateCode), 10);
    tap(1);

    // R6 deadline
    tap(0); tap(0);
    chk("R6 before deadline", int'(stateCode), 2);
    idle(TO + 20);
    chk("R6 deadline", int'(stateCode), 10);
    tap(0);
    chk("R8 after deadline", int'(stateCode), 0);

    idle(5);
    finish_run();
  end
endmodule